// File: doc/BRIEF.md
# Dual-Port Static RAM Write Sequencer

This block sits between a clocked host and one port of an asynchronous dual-port static RAM. A single-cycle request (target, address, 16-bit data, two lane enables, and a flag saying whether the RAM's output enable is to be held active) becomes a complete write cycle on the RAM pins. The cycle has four phases: address setup with the selects asserted, a write strobe, data hold, and write recovery. The host sees `busy` for the whole cycle and a one-cycle `done` when the cycle ends.

The cycle can go to one of two targets. The first is the storage array, selected by a low chip enable. The second is the semaphore latches, selected by a low semaphore select while chip enable stays high. All intervals are whole clock counts set by parameters. When output enable is held low, the RAM may still be driving the shared data pins as the strobe falls. In that case the sequencer waits a turn-off interval before it drives data, and it lengthens the strobe so that the full data setup still fits inside it.

Top module: `dpram_wr_seq`

## Requirements
- R1: While reset is applied and after it is released, ram_ce_n, ram_sem_n, ram_rw_n, ram_oe_n, ram_ub_n and ram_lb_n are high, and ram_dq_oe, busy and done are low.
- R2: A request with at least one lane enable set and sampled while idle is accepted. From the next cycle, busy is high and ram_addr shows the address. ram_rw_n falls exactly T_AS cycles later.
- R3: For target 0 (array), ram_ce_n is low and ram_sem_n is high from acceptance until ram_rw_n rises. ram_ub_n is low when be[1] is set and ram_lb_n is low when be[0] is set. All selects return high in the same cycle that ram_rw_n rises.
- R4: For target 1 (semaphore), ram_sem_n is low and ram_ce_n stays high during the same window, with the lanes set as in R3.
- R5: ram_rw_n stays low for max(T_WP, T_DW) cycles when oe_active is 0. When oe_active is 1, it stays low for max(T_WP, T_WZ + T_DW) cycles.
- R6: ram_dq_oe rises T_WZ cycles after ram_rw_n falls when oe_active is 1, and in the same cycle when oe_active is 0. It stays high for T_DH cycles after ram_rw_n rises. While it is high, ram_dq_o equals wdata.
- R7: ram_oe_n is low from acceptance until the cycle ends when oe_active is 1. Otherwise it stays high.
- R8: ram_addr does not change from acceptance until done, and so it is stable while ram_rw_n is low.
- R9: done is a single-cycle pulse that comes max(T_DH, T_WR) cycles after ram_rw_n rises. busy falls in the same cycle that done rises.
- R10: A request raised while busy is high is dropped. It produces no second strobe, no address change, and no later cycle.
- R11: A request with both lane enables clear is dropped. busy stays low and ram_rw_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Single-cycle write request |
| target | input | 1 | 0 = storage array, 1 = semaphore latches |
| addr | input | ADDR_W | Write address |
| wdata | input | 2*LANE_W | Write data; upper lane is bits [15:8] |
| be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| oe_active | input | 1 | Hold RAM output enable low during the cycle |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_dq_o | output | 2*LANE_W | Data to RAM |
| ram_dq_oe | output | 1 | Enable for the data drivers |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_sem_n | output | 1 | Semaphore select, active low |
| ram_rw_n | output | 1 | Write strobe, low = write |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_ub_n | output | 1 | Upper lane enable, active low |
| ram_lb_n | output | 1 | Lower lane enable, active low |

## Verification
Every pin is registered from the next phase. A request seen at edge E0 therefore shows its address, selects and busy right after E0. The strobe falls after edge E0+T_AS and rises after E0+T_AS+pulse. done appears after E0+T_AS+pulse+max(T_DH,T_WR). The bench samples on the falling clock edge and numbers the samples from the accepting edge. It compares the sample index of each pin change with these sums worked out from the parameters, instead of waiting for the change to show up. A small RAM model on the pins records what was written, so lane masking and semaphore writes are checked after done.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_POST   = 2'd3
  } dpw_phase_e;

  function automatic int unsigned dpw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dpw_req_latch.sv
// Captures one request; exposes current (q) and next (d) values.
module dpw_req_latch #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   data_i,
  input  logic [LANES-1:0]          be_i,
  input  logic                      sem_i,
  input  logic                      oe_i,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   data_q,
  output logic [LANES-1:0]          be_q,
  output logic [LANES-1:0]          be_d,
  output logic                      sem_q,
  output logic                      sem_d,
  output logic                      oe_q,
  output logic                      oe_d
);

  always_comb begin
    be_d  = load_i ? be_i  : be_q;
    sem_d = load_i ? sem_i : sem_q;
    oe_d  = load_i ? oe_i  : oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      sem_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      be_q   <= be_i;
      sem_q  <= sem_i;
      oe_q   <= oe_i;
    end
  end

  // Data lanes held in separate registers, each loaded on acceptance.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g*LANE_W +: LANE_W] <= '0;
      end else if (load_i) begin
        data_q[g*LANE_W +: LANE_W] <= data_i[g*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/dpw_phase_ctl.sv
// Phase sequencer: setup -> strobe -> post (hold and recovery) -> idle.
module dpw_phase_ctl
  import dpw_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned T_AS     = 2,
  parameter int unsigned PULSE_OE = 4,
  parameter int unsigned PULSE_HZ = 3,
  parameter int unsigned POST_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             be_any_i,
  input  logic             oe_q_i,
  output dpw_phase_e       ph_q,
  output dpw_phase_e       ph_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             load_o,
  output logic             finish_o
);

  localparam logic [CNT_W-1:0] AS_LAST   = CNT_W'(T_AS - 1);
  localparam logic [CNT_W-1:0] P_OE_LAST = CNT_W'(PULSE_OE - 1);
  localparam logic [CNT_W-1:0] P_HZ_LAST = CNT_W'(PULSE_HZ - 1);
  localparam logic [CNT_W-1:0] PST_LAST  = CNT_W'(POST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pulse_last;

  assign pulse_last = oe_q_i ? P_OE_LAST : P_HZ_LAST;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q + 1'b1;
    load_o   = 1'b0;
    finish_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req_i && be_any_i) begin
          ph_d   = PH_SETUP;
          load_o = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_q == AS_LAST) begin
          ph_d  = PH_STROBE;
          cnt_d = '0;
        end
      end
      PH_STROBE: begin
        if (cnt_q == pulse_last) begin
          ph_d  = PH_POST;
          cnt_d = '0;
        end
      end
      PH_POST: begin
        if (cnt_q == PST_LAST) begin
          ph_d     = PH_IDLE;
          cnt_d    = '0;
          finish_o = 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dpw_pin_drv.sv
// Registered pin drivers, decoded from the next phase so pins align with it.
module dpw_pin_drv
  import dpw_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned T_WZ  = 2,
  parameter int unsigned T_DH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpw_phase_e       ph_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             sem_d,
  input  logic [LANES-1:0] be_d,
  input  logic             oe_d,
  input  logic             finish_i,
  output logic             ce_n_o,
  output logic             sem_n_o,
  output logic             rw_n_o,
  output logic             oe_n_o,
  output logic [LANES-1:0] be_n_o,
  output logic             dq_oe_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] WZ_CNT = CNT_W'(T_WZ);
  localparam logic [CNT_W-1:0] DH_CNT = CNT_W'(T_DH);

  logic             sel_win;
  logic [CNT_W-1:0] wz_eff;
  logic             ce_n_nx, sem_n_nx, rw_n_nx, oe_n_nx, dq_oe_nx, busy_nx;
  logic [LANES-1:0] be_n_nx;

  always_comb begin
    sel_win  = (ph_d == PH_SETUP) || (ph_d == PH_STROBE);
    wz_eff   = oe_d ? WZ_CNT : '0;
    ce_n_nx  = !(sel_win && !sem_d);
    sem_n_nx = !(sel_win && sem_d);
    rw_n_nx  = (ph_d != PH_STROBE);
    oe_n_nx  = !((ph_d != PH_IDLE) && oe_d);
    busy_nx  = (ph_d != PH_IDLE);
    dq_oe_nx = ((ph_d == PH_STROBE) && (cnt_d >= wz_eff)) ||
               ((ph_d == PH_POST) && (cnt_d < DH_CNT));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_be
    assign be_n_nx[g] = !(sel_win && be_d[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_o  <= 1'b1;
      sem_n_o <= 1'b1;
      rw_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      be_n_o  <= '1;
      dq_oe_o <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      ce_n_o  <= ce_n_nx;
      sem_n_o <= sem_n_nx;
      rw_n_o  <= rw_n_nx;
      oe_n_o  <= oe_n_nx;
      be_n_o  <= be_n_nx;
      dq_oe_o <= dq_oe_nx;
      busy_o  <= busy_nx;
      done_o  <= finish_i;
    end
  end

endmodule

// File: rtl/dpram_wr_seq.sv
module dpram_wr_seq
  import dpw_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_WZ   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  target,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   wdata,
  input  logic [1:0]            be,
  input  logic                  oe_active,
  output logic                  busy,
  output logic                  done,
  output logic [ADDR_W-1:0]     ram_addr,
  output logic [2*LANE_W-1:0]   ram_dq_o,
  output logic                  ram_dq_oe,
  output logic                  ram_ce_n,
  output logic                  ram_sem_n,
  output logic                  ram_rw_n,
  output logic                  ram_oe_n,
  output logic                  ram_ub_n,
  output logic                  ram_lb_n
);

  localparam int unsigned LANES    = 2;
  localparam int unsigned PULSE_OE = dpw_max(T_WP, T_WZ + T_DW);
  localparam int unsigned PULSE_HZ = dpw_max(T_WP, T_DW);
  localparam int unsigned POST_LEN = dpw_max(T_DH, T_WR);
  localparam int unsigned MAX_LEN  = dpw_max(dpw_max(T_AS, PULSE_OE), POST_LEN);
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  dpw_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_d;
  logic             load, finish;
  logic [LANES-1:0] be_q, be_d, be_n;
  logic             sem_q, sem_d, oe_q, oe_d;

  dpw_req_latch #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .addr_i(addr), .data_i(wdata), .be_i(be), .sem_i(target), .oe_i(oe_active),
    .addr_q(ram_addr), .data_q(ram_dq_o), .be_q(be_q), .be_d(be_d),
    .sem_q(sem_q), .sem_d(sem_d), .oe_q(oe_q), .oe_d(oe_d)
  );

  dpw_phase_ctl #(
    .CNT_W(CNT_W), .T_AS(T_AS), .PULSE_OE(PULSE_OE),
    .PULSE_HZ(PULSE_HZ), .POST_LEN(POST_LEN)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .req_i(req), .be_any_i(|be), .oe_q_i(oe_q),
    .ph_q(ph_q), .ph_d(ph_d), .cnt_d(cnt_d), .load_o(load), .finish_o(finish)
  );

  dpw_pin_drv #(.CNT_W(CNT_W), .LANES(LANES), .T_WZ(T_WZ), .T_DH(T_DH)) u_pins (
    .clk(clk), .rst_n(rst_n), .ph_d(ph_d), .cnt_d(cnt_d),
    .sem_d(sem_d), .be_d(be_d), .oe_d(oe_d), .finish_i(finish),
    .ce_n_o(ram_ce_n), .sem_n_o(ram_sem_n), .rw_n_o(ram_rw_n), .oe_n_o(ram_oe_n),
    .be_n_o(be_n), .dq_oe_o(ram_dq_oe), .busy_o(busy), .done_o(done)
  );

  assign ram_ub_n = be_n[1];
  assign ram_lb_n = be_n[0];

endmodule

// File: rtl/dpw_wr_seq_chk.sv
module dpw_wr_seq_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned T_WP   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_dq_oe,
  input logic              ram_ce_n,
  input logic              ram_sem_n,
  input logic              ram_rw_n,
  input logic              ram_oe_n
);

  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lo_cnt <= '0;
    else if (!ram_rw_n) lo_cnt <= lo_cnt + 1'b1;
    else                lo_cnt <= '0;
  end

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr));

  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_ce_n && !ram_sem_n));

  a_r5_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rw_n |-> (!ram_ce_n || !ram_sem_n));

  a_r5_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_rw_n) |-> (lo_cnt >= 16'(T_WP)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ram_rw_n && $past(busy)));

  a_r6_drive_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> busy);

  a_r7_oe_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ram_oe_n);

  a_r2_strobe_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_rw_n) |-> busy);

endmodule

bind dpram_wr_seq dpw_wr_seq_chk #(.ADDR_W(ADDR_W), .T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ram_addr(ram_addr),
  .ram_dq_oe(ram_dq_oe), .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n),
  .ram_rw_n(ram_rw_n), .ram_oe_n(ram_oe_n)
);

// File: tb/sim_dpram_wr_seq.sv
`timescale 1ns/1ps
module sim_dpram_wr_seq;

  localparam int AW = 8;
  localparam int AS = 2, WP = 3, DWS = 2, WZ = 2, DH = 1, WR = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, target, oe_active;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [1:0]    be;
  logic          busy, done, ram_dq_oe, ram_ce_n, ram_sem_n, ram_rw_n, ram_oe_n, ram_ub_n, ram_lb_n;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_dq_o;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] mem [256];
  logic        semb [8];

  always #4 clk = ~clk;

  dpram_wr_seq #(.ADDR_W(AW), .LANE_W(8), .T_AS(AS), .T_WP(WP), .T_DW(DWS),
                 .T_WZ(WZ), .T_DH(DH), .T_WR(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .target(target), .addr(addr), .wdata(wdata),
    .be(be), .oe_active(oe_active), .busy(busy), .done(done), .ram_addr(ram_addr),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n),
    .ram_rw_n(ram_rw_n), .ram_oe_n(ram_oe_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n)
  );

  // RAM model on the pins
  always @(negedge clk) begin
    if (!ram_rw_n && ram_dq_oe && !ram_ce_n) begin
      if (!ram_ub_n) mem[ram_addr][15:8] <= ram_dq_o[15:8];
      if (!ram_lb_n) mem[ram_addr][7:0]  <= ram_dq_o[7:0];
    end
    if (!ram_rw_n && ram_dq_oe && !ram_sem_n && !ram_lb_n)
      semb[ram_addr[2:0]] <= ram_dq_o[0];
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One write; poke_at > 0 raises a second request at that sample (R10).
  task automatic do_write(input bit tgt, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] b, input bit oe, input int poke_at);
    int p, lpost, wz, s_lo, n_lo, n_fall, dq_first, dq_last, done_at, n_done;
    int bad_addr, bad_sel, bad_dat, bad_oe, bad_busy, rel_bad;
    logic prev_rw;
    logic [15:0] exp_mem;
    logic exp_sem;
    p = oe ? imax(WP, WZ + DWS) : imax(WP, DWS);
    lpost = imax(DH, WR);
    wz = oe ? WZ : 0;
    exp_mem = mem[a];
    if (b[1]) exp_mem[15:8] = d[15:8];
    if (b[0]) exp_mem[7:0]  = d[7:0];
    exp_sem = b[0] ? d[0] : semb[a[2:0]];
    s_lo = 0; n_lo = 0; n_fall = 0; dq_first = 0; dq_last = 0; done_at = 0; n_done = 0;
    bad_addr = 0; bad_sel = 0; bad_dat = 0; bad_oe = 0; bad_busy = 0; rel_bad = 0;
    prev_rw = 1'b1;
    req = 1'b1; target = tgt; addr = a; wdata = d; be = b; oe_active = oe;
    for (int s = 1; s <= 40 && done_at == 0; s++) begin
      @(negedge clk);
      if (s == poke_at) begin
        req = 1'b1; addr = a ^ 8'h5A; wdata = ~d; be = 2'b11; target = ~tgt;
      end else begin
        req = 1'b0;
      end
      if (ram_addr !== a) bad_addr++;
      if (done) begin
        done_at = s; n_done++;
        if (busy !== 1'b0) bad_busy++;
      end else if (busy !== 1'b1) bad_busy++;
      if (prev_rw && !ram_rw_n) n_fall++;
      prev_rw = ram_rw_n;
      if (!ram_rw_n) begin
        n_lo++;
        if (s_lo == 0) s_lo = s;
      end
      if (s <= AS + p) begin
        if (ram_ce_n !== tgt || ram_sem_n !== !tgt || ram_ub_n !== !b[1] || ram_lb_n !== !b[0])
          bad_sel++;
      end else if (!(ram_ce_n && ram_sem_n && ram_ub_n && ram_lb_n)) rel_bad++;
      if (ram_dq_oe) begin
        if (dq_first == 0) dq_first = s;
        dq_last = s;
        if (ram_dq_o !== d) bad_dat++;
      end
      if (!done && ram_oe_n !== !oe) bad_oe++;
      if (done && ram_oe_n !== 1'b1) bad_oe++;
    end
    if (done_at == 0) check("R9 watchdog: done never seen", 0, 1);
    check("R2 strobe falls after setup", s_lo, AS + 1);
    check("R5 strobe low length", n_lo, p);
    check("R10 single strobe per cycle", n_fall, 1);
    check(tgt ? "R4 semaphore selects" : "R3 array selects", bad_sel, 0);
    check("R3 selects released with strobe", rel_bad, 0);
    check("R6 drive start", dq_first, AS + 1 + wz);
    check("R6 drive end", dq_last, AS + p + DH);
    check("R6 driven data", bad_dat, 0);
    check("R7 output enable level", bad_oe, 0);
    check("R8 address stable", bad_addr, 0);
    check("R9 done timing", done_at, AS + p + lpost + 1);
    check("R9 busy until done", bad_busy, 0);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
    if (tgt) check("R4 semaphore bit written", semb[a[2:0]], exp_sem);
    else     check("R3 array lanes written", mem[a], exp_mem);
    if (poke_at > 0) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (busy || !ram_rw_n) begin
          check("R10 ignored request started a cycle", 1, 0);
          break;
        end
      end
      check("R10 address after ignored request", ram_addr, a);
    end
  endtask

  task automatic t_reset();
    check("R1 reset ce_n", ram_ce_n, 1);
    check("R1 reset sem_n", ram_sem_n, 1);
    check("R1 reset rw_n", ram_rw_n, 1);
    check("R1 reset oe_n", ram_oe_n, 1);
    check("R1 reset lanes", {ram_ub_n, ram_lb_n}, 3);
    check("R1 reset dq_oe/busy/done", {ram_dq_oe, busy, done}, 0);
  endtask

  task automatic t_no_lanes();
    int bad;
    bad = 0;
    req = 1'b1; target = 1'b0; addr = 8'h33; wdata = 16'hDEAD; be = 2'b00; oe_active = 1'b0;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (busy || !ram_rw_n || !ram_ce_n) bad++;
      @(negedge clk);
    end
    check("R11 empty lane request ignored", bad, 0);
    check("R11 memory untouched", mem[8'h33], 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) semb[i] = 1'b0;
    req = 0; target = 0; addr = '0; wdata = '0; be = '0; oe_active = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_write(1'b0, 8'h10, 16'hA55A, 2'b11, 1'b0, 0);
    do_write(1'b0, 8'h10, 16'h1234, 2'b01, 1'b1, 0);
    do_write(1'b0, 8'h10, 16'hBEEF, 2'b10, 1'b1, 0);
    do_write(1'b1, 8'h03, 16'h0001, 2'b01, 1'b0, 0);
    do_write(1'b1, 8'h05, 16'h0001, 2'b11, 1'b1, 0);
    do_write(1'b0, 8'h20, 16'hC3C3, 2'b11, 1'b1, 3);
    do_write(1'b0, 8'h21, 16'h7E7E, 2'b11, 1'b0, 5);
    check("R10 poked address not written", mem[8'h20 ^ 8'h5A], 16'h0000);
    t_no_lanes();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    summary();
  end

endmodule